// File: doc/BRIEF.md
# ADC Power-Up Initialization Sequencer

This block sits on the digital side of a two-channel audio converter. It runs a fixed settling period each time the converter path wakes from a fully powered-down state. It watches one power-enable bit per channel. When both bits were low and at least one of them goes high, it starts counting sample periods. A single-cycle strobe, issued once per sample period, marks each period.

While the count runs, both channel outputs are held at the two's-complement value zero, so any start-up transient in the converted data never reaches downstream logic. Once the count expires, the incoming samples pass straight through. A 2-bit length code picks one of four period counts. The code is captured when the count starts. The same gating applies whether the samples come from the analog converter or from a digital microphone front end, because the block sees only the sample words.

Top module: `adc_init_seq`

## Requirements
- R1: In the first clock cycle in which the power-enable bits are nonzero, having been 00 in the previous cycle, a count starts, and `init_busy` is high in the following cycle. Either channel alone (bit 0 = left, bit 1 = right) is enough to start it.
- R2: The length code on `len_sel` selects the number of sample strobes: 2'b00 selects 1059, 2'b01 selects 267, 2'b10 selects 531 and 2'b11 selects 135. `init_busy` stays high through N-1 strobes and is low in the cycle after the N-th strobe.
- R3: After reset, `init_busy` is low and both outputs equal their inputs.
- R4: While `init_busy` is high, both `smp_l_out` and `smp_r_out` are zero.
- R5: While `init_busy` is low, `smp_l_out` equals `smp_l_in` and `smp_r_out` equals `smp_r_in`.
- R6: Enabling the second channel while the first is already enabled neither restarts nor extends a running count.
- R7: When both power-enable bits are 0, `init_busy` is low in the next cycle. A later power-up starts a fresh full-length count.
- R8: `len_sel` is sampled only in the start cycle. Changing it during a count has no effect on that count's length.
- R9: The count advances only in cycles where `fs_tick` is high. With no strobes, `init_busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 2 | Channel power enables, bit 0 left, bit 1 right |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| len_sel | input | 2 | Initialization length code |
| smp_l_in | input | DATA_W | Left sample from the converter |
| smp_r_in | input | DATA_W | Right sample from the converter |
| smp_l_out | output | DATA_W | Gated left sample |
| smp_r_out | output | DATA_W | Gated right sample |
| init_busy | output | 1 | High for the whole initialization period |

## Verification
The assertions assume that `pwr_en` is held at 00 for as long as reset is applied. The start check compares the current power bits with their value one clock earlier, and it only agrees with the edge detector's reset state if the bits were 00 during reset. The bench keeps `pwr_en` at zero until reset is released. It changes every input on the falling clock edge, which gives each rising edge a clean, single-cycle `fs_tick` pulse. Sample words are held at distinct nonzero patterns, so that a pass-through and a forced zero can be told apart.

// File: rtl/adc_init_pkg.sv
// Package: shared constants and the length-code decode for the ADC
// initialization sequencer.
// Assumes: the four period counts are fixed by the converter's settling needs.
package adc_init_pkg;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned LEN_MAX  = 1059;
    localparam int unsigned CNT_W    = $clog2(LEN_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    // Map the 2-bit length code to a number of sample periods (non-monotonic).
    function automatic cnt_t len_decode(input logic [1:0] code);
        cnt_t n;
        case (code)
            2'b00:   n = cnt_t'(1059);
            2'b01:   n = cnt_t'(267);
            2'b10:   n = cnt_t'(531);
            default: n = cnt_t'(135);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwr_edge_detect.sv
// Module: pwr_edge_detect
// Detects the "all channels off" to "any channel on" transition of the
// per-channel power enables and reports the "all off" state.
// Assumes: the power enables are synchronous to clk.
module pwr_edge_detect #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwr_en_i,
    output logic              start_o,
    output logic              all_off_o
);

    logic [NUM_CH-1:0] prev_q;

    // Keep last cycle's power enables for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pwr_en_i;
    end

    // Start when nothing was on before and something is on now.
    always_comb begin
        all_off_o = ~|pwr_en_i;
        start_o   = (~|prev_q) & (|pwr_en_i);
    end

    // R6: once any channel was on, a further enable never yields a start.
    a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (|prev_q) |-> !start_o);

endmodule

// File: rtl/init_counter.sv
// Module: init_counter
// Loads the decoded period count on a start, counts down once per sample
// strobe and drives the busy flag while the count is nonzero.
// Assumes: clear and load are never high together (guaranteed by the
// edge detector).
module init_counter
    import adc_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       clear_i,
    input  logic       tick_i,
    input  logic [1:0] len_sel_i,
    output logic       busy_o
);

    cnt_t cnt_q;

    // Clear on power-down, load on start, otherwise step down on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_decode(len_sel_i);
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - cnt_t'(1);
        end
    end

    // Busy while periods remain.
    always_comb busy_o = (cnt_q != '0);

    // R2: the count never goes above the longest setting.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cnt_t'(LEN_MAX));

    // R9: with no strobe, load or clear, a running count holds.
    a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i && !load_i && !clear_i) |=> $stable(cnt_q));

    // Clear and load come from exclusive conditions.
    a_r7_excl_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && load_i));

endmodule

// File: rtl/sample_gate.sv
// Module: sample_gate
// Forces each channel's sample to zero while muted, else passes it through.
// Assumes: the mute control is already aligned to the sample words.
module sample_gate #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DATA_W = 24
) (
    input  logic                           mute_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  smp_i,
    output logic [NUM_CH-1:0][DATA_W-1:0]  smp_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Zero this channel during initialization.
        always_comb smp_o[ch] = mute_i ? '0 : smp_i[ch];
    end

endmodule

// File: rtl/adc_init_seq.sv
// Module: adc_init_seq (top)
// Runs the power-up initialization period of a stereo ADC path and gates
// both sample streams to zero while it lasts.
// Assumes: pwr_en is 00 while reset is applied; fs_tick is one clock wide.
module adc_init_seq #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pwr_en,
    input  logic              fs_tick,
    input  logic [1:0]        len_sel,
    input  logic [DATA_W-1:0] smp_l_in,
    input  logic [DATA_W-1:0] smp_r_in,
    output logic [DATA_W-1:0] smp_l_out,
    output logic [DATA_W-1:0] smp_r_out,
    output logic              init_busy
);
    import adc_init_pkg::*;

    logic start, all_off;
    logic [NUM_CH-1:0][DATA_W-1:0] smp_in, smp_out;

    pwr_edge_detect #(.NUM_CH(NUM_CH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en_i (pwr_en),
        .start_o  (start),
        .all_off_o(all_off)
    );

    init_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .clear_i  (all_off),
        .tick_i   (fs_tick),
        .len_sel_i(len_sel),
        .busy_o   (init_busy)
    );

    // Pack the channel inputs, index 0 left and 1 right.
    always_comb begin
        smp_in[0] = smp_l_in;
        smp_in[1] = smp_r_in;
    end

    sample_gate #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_gate (
        .mute_i(init_busy),
        .smp_i (smp_in),
        .smp_o (smp_out)
    );

    // Unpack the gated outputs.
    always_comb begin
        smp_l_out = smp_out[0];
        smp_r_out = smp_out[1];
    end

    // R1: a both-off to any-on transition makes busy high next cycle.
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_en) == 2'b00 && pwr_en != 2'b00) |=> init_busy);

    // R7: all channels off drops busy next cycle.
    a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en == 2'b00) |=> !init_busy);

    // R4: outputs are zero during initialization.
    a_r4_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (smp_l_out == '0 && smp_r_out == '0));

    // R5: outputs follow inputs once initialization is over.
    a_r5_pass_out: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |-> (smp_l_out == smp_l_in && smp_r_out == smp_r_in));

endmodule

// File: tb/test_adc_init_seq.sv
module test_adc_init_seq;
    localparam int DW = 24;
    localparam logic [DW-1:0] PAT_L = 24'hA5C3F1;
    localparam logic [DW-1:0] PAT_R = 24'h3C7E09;

    logic clk = 1'b0, rst_n = 1'b0, fs_tick = 1'b0;
    logic [1:0] pwr_en = 2'b00, len_sel = 2'b00;
    logic [DW-1:0] smp_l_in = PAT_L, smp_r_in = PAT_R, smp_l_out, smp_r_out;
    logic init_busy;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    adc_init_seq #(.DATA_W(DW)) i_adc_init_seq (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .fs_tick(fs_tick),
        .len_sel(len_sel), .smp_l_in(smp_l_in), .smp_r_in(smp_r_in),
        .smp_l_out(smp_l_out), .smp_r_out(smp_r_out), .init_busy(init_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            fs_tick = 1'b1; cyc(1);
        end
        fs_tick = 1'b0;
    endtask

    task automatic go_idle();
        pwr_en = 2'b00; cyc(2);
    endtask

    // R1/R2/R4/R5: run one full count and check its length and gating.
    task automatic t_length(input logic [1:0] code, input int n, input logic [1:0] en);
        len_sel = code; pwr_en = en; cyc(1);
        chk(init_busy == 1'b1, "R1 busy after power-up", DW'(init_busy), 1);
        chk(smp_l_out == '0 && smp_r_out == '0, "R4 zero during init", smp_l_out, 0);
        ticks(n - 1);
        chk(init_busy == 1'b1, "R2 busy before last strobe", DW'(init_busy), 1);
        ticks(1);
        chk(init_busy == 1'b0, "R2 idle after last strobe", DW'(init_busy), 0);
        chk(smp_l_out == PAT_L, "R5 left pass", smp_l_out, PAT_L);
        chk(smp_r_out == PAT_R, "R5 right pass", smp_r_out, PAT_R);
        go_idle();
    endtask

    // R3: reset state.
    task automatic t_reset();
        chk(init_busy == 1'b0, "R3 busy low at reset", DW'(init_busy), 0);
        chk(smp_l_out == PAT_L, "R3 pass at reset", smp_l_out, PAT_L);
    endtask

    // R6: second channel on mid-count does not extend.
    task automatic t_second_ch();
        len_sel = 2'b11; pwr_en = 2'b01; cyc(1);
        ticks(100);
        pwr_en = 2'b11; cyc(1);
        ticks(34);
        chk(init_busy == 1'b1, "R6 still busy", DW'(init_busy), 1);
        ticks(1);
        chk(init_busy == 1'b0, "R6 no restart", DW'(init_busy), 0);
        go_idle();
    endtask

    // R7: power-down aborts; fresh power-up restarts full length.
    task automatic t_abort();
        len_sel = 2'b11; pwr_en = 2'b10; cyc(1);
        ticks(50);
        pwr_en = 2'b00; cyc(1);
        chk(init_busy == 1'b0, "R7 idle on off", DW'(init_busy), 0);
        pwr_en = 2'b10; cyc(1);
        ticks(134);
        chk(init_busy == 1'b1, "R7 fresh full count", DW'(init_busy), 1);
        ticks(1);
        chk(init_busy == 1'b0, "R7 fresh count ends", DW'(init_busy), 0);
        go_idle();
    endtask

    // R8: changing len_sel mid-count has no effect.
    task automatic t_latch();
        len_sel = 2'b11; pwr_en = 2'b01; cyc(1);
        len_sel = 2'b00;
        ticks(134);
        chk(init_busy == 1'b1, "R8 busy before end", DW'(init_busy), 1);
        ticks(1);
        chk(init_busy == 1'b0, "R8 latched length", DW'(init_busy), 0);
        go_idle();
    endtask

    // R9: no strobes, no progress.
    task automatic t_no_tick();
        len_sel = 2'b11; pwr_en = 2'b01; cyc(1);
        ticks(134);
        cyc(300);
        chk(init_busy == 1'b1, "R9 holds without strobe", DW'(init_busy), 1);
        chk(smp_r_out == '0, "R4 zero while held", smp_r_out, 0);
        ticks(1);
        chk(init_busy == 1'b0, "R9 ends on strobe", DW'(init_busy), 0);
        go_idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset();
        t_length(2'b00, 1059, 2'b01);
        t_length(2'b01, 267, 2'b10);
        t_length(2'b10, 531, 2'b11);
        t_length(2'b11, 135, 2'b01);
        t_second_ch();
        t_abort();
        t_latch();
        t_no_tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule